// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This block keeps time from a 32.768 kHz clock. A 47-bit counter advances once per rising edge of the slow clock. Its 15 least significant bits are sub-second ticks, and the 32 bits above them hold whole seconds. Software on a fast 32-bit register bus can load the counter while the counter is stopped. It can program a seconds alarm, start and stop the counter and the alarm, and clear the alarm flag. An interrupt or wakeup line reports a pending alarm.

The slow clock is not used as a clock inside the block. It is synchronized into the bus clock domain, and each rising edge becomes a one-cycle tick. All timekeeping state advances on these ticks. The three enable bits written by software pass through a line of three tick-clocked stages before they act. Software therefore has to poll until the counter-enable read-back matches what it wrote. The two counter halves are read at different bus cycles and are not latched together, so a read that straddles a tick can return halves that do not belong together.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset every register listed in R3, R5, R6 and R11 reads zero, and `irq_o` is low.
- R2: While the counter is effectively enabled, it increases by exactly one per rising edge of `slow_clk_i`. It wraps from 2^47-1 to 0, and a carry out of bit 31 reaches the high half.
- R3: Offset 0x20 reads and writes counter bits 31:0. Offset 0x1C reads counter bits 46:32 in bits 14:0, with bits 31:15 reading zero. A write to 0x1C loads counter bits 46:32 from write bits 14:0 and drops write bits 31:15.
- R4: Writes to 0x20 and 0x1C are ignored while the effective counter enable is 1.
- R5: Control is at 0x04: bit 0 is counter enable, bit 1 is alarm enable, bit 3 is wakeup enable. A written value takes effect after exactly three slow-clock rising edges. Read-back bit 0 shows the effective counter enable. Read-back bits 1 and 3 show the written values.
- R6: Offset 0x24 holds the 32-bit alarm seconds. Status bit 0 at 0x18 sets on the slow edge that carries the seconds field to a value equal to the alarm, provided the counter and alarm enables are both effective.
- R7: The status flag does not set while the effective alarm enable is 0. It also does not set on edges that leave the seconds field unchanged, even when the seconds field already equals the alarm.
- R8: Writing 0x18 with bit 0 set clears the status flag. Writing it with bit 0 clear leaves the flag as it was.
- R9: Writes to 0x24 are ignored while the effective alarm enable is 1.
- R10: `irq_o` is high exactly when the status flag, the effective alarm enable and the effective wakeup enable are all 1.
- R11: Offset 0x30 is a 32-bit storage register for the glitch-detector setup value and reads back what was written. Any unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | 1 | 32.768 kHz time base, asynchronous to clk |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt and wakeup request |

## Verification
The counting behaviour is checked by loading a set of start values and reading both halves after every slow edge. The start values are chosen to separate four cases: a plain increment, a roll of the sub-second field into the seconds, a carry from the low word into the high word, and the full 47-bit wrap. Alarm patterns approach the alarm second from just below it, both with and without the alarm enable, and also start already inside the alarm second. This tells a true seconds-rollover compare apart from a level compare. Enable, counter-load and alarm-load writes are issued at tick counts on either side of the three-edge window, which checks that the delay is exact and that writes made while enabled are blocked.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    // Register byte offsets decoded by software
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_GUARD  = 8'h30;

    // Control register bit positions
    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_ALM  = 1;
    localparam int unsigned CB_WAKE = 3;

    // Index of each enable inside the internal enable vector
    localparam int unsigned EN_N    = 3;
    localparam int unsigned IX_RUN  = 0;
    localparam int unsigned IX_ALM  = 1;
    localparam int unsigned IX_WAKE = 2;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int unsigned SYNC_FF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_clk_i,
    output logic tick_o
);
    typedef struct packed {
        logic [SYNC_FF-1:0] sync;
        logic               prev;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_FF-2:0], slow_clk_i};
        s_d.prev = s_q.sync[SYNC_FF-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // One bus-clock pulse per rising slow edge
    assign tick_o = s_q.sync[SYNC_FF-1] & ~s_q.prev;
endmodule

// File: rtl/rtc_en_delay.sv
module rtc_en_delay #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] eff_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stg;
    } dly_st_t;

    dly_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            s_d.stg[0] = req_i;
            for (int i = 1; i < DEPTH; i++) begin
                s_d.stg[i] = s_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: enables act DEPTH slow edges after they are written
    assign eff_o = s_q.stg[DEPTH-1];
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int unsigned CNT_W  = 47,
    parameter int unsigned FRAC_W = 15,
    parameter int unsigned REG_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    run_i,
    input  logic                    alarm_en_i,
    input  logic                    lo_we_i,
    input  logic                    hi_we_i,
    input  logic                    alarm_we_i,
    input  logic                    stat_clr_i,
    input  logic [REG_W-1:0]        wdata_i,
    output logic [CNT_W-1:0]        count_o,
    output logic [CNT_W-FRAC_W-1:0] alarm_o,
    output logic                    flag_o
);
    localparam int unsigned SEC_W = CNT_W - FRAC_W;
    localparam int unsigned HI_W  = CNT_W - REG_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEC_W-1:0] alarm;
        logic             flag;
    } core_st_t;

    core_st_t         s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             sec_roll;
    logic             hit;

    always_comb begin
        s_d      = s_q;
        cnt_inc  = s_q.cnt + 1'b1;
        sec_roll = (cnt_inc[FRAC_W-1:0] == '0);
        hit      = tick_i && run_i && alarm_en_i && sec_roll &&
                   (cnt_inc[CNT_W-1:FRAC_W] == s_q.alarm);

        // R2, R4: count on ticks while running, load only while stopped
        if (tick_i && run_i) begin
            s_d.cnt = cnt_inc;
        end else if (!run_i) begin
            if (lo_we_i) s_d.cnt[REG_W-1:0]     = wdata_i;
            if (hi_we_i) s_d.cnt[CNT_W-1:REG_W] = wdata_i[HI_W-1:0];
        end

        // R9: alarm value frozen while the alarm is live
        if (alarm_we_i && !alarm_en_i) s_d.alarm = wdata_i[SEC_W-1:0];

        // R6, R7, R8: a set in the same cycle as a clear wins
        if (stat_clr_i) s_d.flag = 1'b0;
        if (hit)        s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign alarm_o = s_q.alarm;
    assign flag_o  = s_q.flag;
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
    import rtc_lp_pkg::*;
#(
    parameter int unsigned CNT_W    = 47,
    parameter int unsigned FRAC_W   = 15,
    parameter int unsigned SYNC_FF  = 2,
    parameter int unsigned EN_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    localparam int unsigned SEC_W = CNT_W - FRAC_W;
    localparam int unsigned HI_W  = CNT_W - REG_W;

    typedef struct packed {
        logic [EN_N-1:0]  req;
        logic [REG_W-1:0] guard;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tick;
    logic [EN_N-1:0]  en_eff;
    logic [CNT_W-1:0] count;
    logic [SEC_W-1:0] alarm_val;
    logic             alarm_flag;
    logic             wr_lo, wr_hi, wr_alarm, wr_stat_clr;

    assign wr_lo       = bus_we_i && (bus_addr_i == OFS_CNT_LO);
    assign wr_hi       = bus_we_i && (bus_addr_i == OFS_CNT_HI);
    assign wr_alarm    = bus_we_i && (bus_addr_i == OFS_ALARM);
    assign wr_stat_clr = bus_we_i && (bus_addr_i == OFS_STAT) && bus_wdata_i[0];

    always_comb begin
        r_d = r_q;
        if (bus_we_i && bus_addr_i == OFS_CTRL) begin
            r_d.req[IX_RUN]  = bus_wdata_i[CB_RUN];
            r_d.req[IX_ALM]  = bus_wdata_i[CB_ALM];
            r_d.req[IX_WAKE] = bus_wdata_i[CB_WAKE];
        end
        // R11
        if (bus_we_i && bus_addr_i == OFS_GUARD) r_d.guard = bus_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    rtc_tick_gen #(.SYNC_FF(SYNC_FF)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk_i(slow_clk_i),
        .tick_o    (tick)
    );

    rtc_en_delay #(.WIDTH(EN_N), .DEPTH(EN_DELAY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .req_i (r_q.req),
        .eff_o (en_eff)
    );

    rtc_time_core #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .REG_W(REG_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (en_eff[IX_RUN]),
        .alarm_en_i(en_eff[IX_ALM]),
        .lo_we_i   (wr_lo),
        .hi_we_i   (wr_hi),
        .alarm_we_i(wr_alarm),
        .stat_clr_i(wr_stat_clr),
        .wdata_i   (bus_wdata_i),
        .count_o   (count),
        .alarm_o   (alarm_val),
        .flag_o    (alarm_flag)
    );

    // R3, R5: halves are read live, never latched together
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_CTRL: begin
                bus_rdata_o[CB_RUN]  = en_eff[IX_RUN];
                bus_rdata_o[CB_ALM]  = r_q.req[IX_ALM];
                bus_rdata_o[CB_WAKE] = r_q.req[IX_WAKE];
            end
            OFS_STAT:   bus_rdata_o[0]        = alarm_flag;
            OFS_CNT_HI: bus_rdata_o[HI_W-1:0] = count[CNT_W-1:REG_W];
            OFS_CNT_LO: bus_rdata_o           = count[REG_W-1:0];
            OFS_ALARM:  bus_rdata_o           = alarm_val;
            OFS_GUARD:  bus_rdata_o           = r_q.guard;
            default:    bus_rdata_o           = '0;
        endcase
    end

    // R10
    assign irq_o = alarm_flag & en_eff[IX_ALM] & en_eff[IX_WAKE];
endmodule

// File: rtl/rtc_lp_chk.sv
module rtc_lp_chk
    import rtc_lp_pkg::*;
#(
    parameter int unsigned CNT_W = 47,
    parameter int unsigned SEC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [EN_N-1:0]   eff,
    input logic [CNT_W-1:0]  count,
    input logic [SEC_W-1:0]  alarm,
    input logic              flag,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff[IX_RUN]) |=> (count == $past(count) + 1'b1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && eff[IX_RUN]) |=> $stable(count));

    // R5
    en_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eff) |-> $past(tick));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(tick) && $past(eff[IX_ALM]) && $past(eff[IX_RUN])));

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_STAT && wdata[0] && !tick) |=> !flag);

    // R9
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff[IX_ALM] |=> $stable(alarm));
endmodule

bind rtc_lp_top rtc_lp_chk #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .eff  (en_eff),
    .count(count),
    .alarm(alarm_val),
    .flag (alarm_flag),
    .we   (bus_we_i),
    .addr (bus_addr_i),
    .wdata(bus_wdata_i)
);

// File: tb/rtc_lp_top_tb_top.sv
module rtc_lp_top_tb_top;
    import rtc_lp_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;

    // reference state derived from the requirements
    logic [46:0] m_cnt = '0;
    logic [2:0]  m_req = '0;
    logic [2:0]  m_s0 = '0, m_s1 = '0, m_s2 = '0;
    logic [31:0] m_alarm = '0;
    logic        m_flag = 1'b0;
    logic [31:0] m_guard = '0;

    always #4 clk = ~clk;

    rtc_lp_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk_i (slow),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a == OFS_CTRL) m_req = {d[3], d[1], d[0]};
        if (a == OFS_STAT && d[0]) m_flag = 1'b0;
        if (a == OFS_CNT_LO && !m_s2[0]) m_cnt[31:0] = d;
        if (a == OFS_CNT_HI && !m_s2[0]) m_cnt[46:32] = d[14:0];
        if (a == OFS_ALARM && !m_s2[1]) m_alarm = d;
        if (a == OFS_GUARD) m_guard = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic slow_tick();
        logic [46:0] nxt;
        slow = 1'b1;
        repeat (8) @(negedge clk);
        slow = 1'b0;
        repeat (8) @(negedge clk);
        if (m_s2[0]) begin
            nxt = m_cnt + 47'd1;
            if (nxt[14:0] == 15'd0 && m_s2[1] && nxt[46:15] == m_alarm) m_flag = 1'b1;
            m_cnt = nxt;
        end
        m_s2 = m_s1; m_s1 = m_s0; m_s0 = m_req;
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            slow_tick();
            check_all(tag);
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [31:0] e;
        e = '0; e[3] = m_req[2]; e[1] = m_req[1]; e[0] = m_s2[0];
        rd(OFS_CTRL, v);   chk({tag, " ctrl"}, 64'(v), 64'(e));
        rd(OFS_STAT, v);   chk({tag, " stat"}, 64'(v), 64'(m_flag));
        rd(OFS_CNT_HI, v); chk({tag, " cnt_hi"}, 64'(v), 64'(m_cnt[46:32]));
        rd(OFS_CNT_LO, v); chk({tag, " cnt_lo"}, 64'(v), 64'(m_cnt[31:0]));
        rd(OFS_ALARM, v);  chk({tag, " alarm"}, 64'(v), 64'(m_alarm));
        chk({tag, " irq"}, 64'(irq), 64'(m_flag & m_s2[1] & m_s2[2]));
    endtask

    task automatic load_cnt(input logic [46:0] c);
        wr(OFS_CNT_LO, c[31:0]);
        wr(OFS_CNT_HI, {17'h1FFFF, c[46:32]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [46:0] starts [4];
        starts[0] = 47'd0;
        starts[1] = 47'h0000_0000_7FFE;
        starts[2] = 47'h0000_FFFF_FFFE;
        starts[3] = 47'h7FFF_FFFF_FFFE;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check_all("R1");
        rd(OFS_GUARD, v); chk("R1 guard", 64'(v), 64'(0));

        // R3: halves map and high-half masking
        load_cnt(47'h2345_DEAD_BEEF);
        check_all("R3");

        // R5: exact three-edge enable delay
        wr(OFS_CTRL, 32'h1);
        ticks(2, "R5");
        rd(OFS_CTRL, v); chk("R5 not yet", 64'(v[0]), 64'(0));
        ticks(1, "R5");
        rd(OFS_CTRL, v); chk("R5 taken", 64'(v[0]), 64'(1));

        // R4: loads blocked while running
        wr(OFS_CNT_LO, 32'h0);
        wr(OFS_CNT_HI, 32'h0);
        check_all("R4");
        ticks(2, "R4");

        // R2: sweep start values around carries and wrap
        foreach (starts[k]) begin
            wr(OFS_CTRL, 32'h0);
            ticks(3, "R2");
            load_cnt(starts[k]);
            wr(OFS_CTRL, 32'h1);
            ticks(8, "R2");
        end

        // R6, R10: alarm on seconds rollover with irq
        wr(OFS_CTRL, 32'h0);
        ticks(3, "R6");
        load_cnt({32'd10, 15'h7FFC});
        wr(OFS_ALARM, 32'd11);
        wr(OFS_CTRL, 32'hB);
        ticks(8, "R6");
        chk("R6 flag", 64'(m_flag), 64'(1));
        chk("R10 irq up", 64'(irq), 64'(1));

        // R9: alarm write blocked while alarm live
        wr(OFS_ALARM, 32'h55);
        check_all("R9");

        // R10: wake off masks irq, flag stays
        wr(OFS_CTRL, 32'h3);
        ticks(3, "R10");
        chk("R10 masked", 64'(irq), 64'(0));

        // R8: write-one-to-clear
        wr(OFS_STAT, 32'h0);
        check_all("R8");
        wr(OFS_STAT, 32'h1);
        check_all("R8");

        // R7: alarm disabled across a rollover
        wr(OFS_CTRL, 32'h0);
        ticks(3, "R7");
        load_cnt({32'd20, 15'h7FFE});
        wr(OFS_ALARM, 32'd21);
        wr(OFS_CTRL, 32'h1);
        ticks(7, "R7");
        // R7: already inside the alarm second, no rollover
        wr(OFS_CTRL, 32'h0);
        ticks(3, "R7");
        load_cnt({32'd30, 15'h0010});
        wr(OFS_ALARM, 32'd30);
        wr(OFS_CTRL, 32'hB);
        ticks(10, "R7");
        chk("R7 no flag", 64'(m_flag), 64'(0));

        // R11: guard register and unmapped offsets
        wr(OFS_GUARD, 32'h4173_6166);
        rd(OFS_GUARD, v); chk("R11 guard", 64'(v), 64'(m_guard));
        rd(8'h08, v);     chk("R11 unmapped", 64'(v), 64'(0));
        rd(8'h3C, v);     chk("R11 unmapped", 64'(v), 64'(0));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule